// File: doc/BRIEF.md
# Guarded Packed-Byte Saturating Adder

This unit is a pipelined SIMD datapath slice. It takes two 32-bit operand words, each holding four byte lanes. In every lane it adds the byte from the first word, read as unsigned, to the byte from the second word, read as two's-complement. The exact sum is clamped into the unsigned byte range, and the four clamped bytes are packed back into one 32-bit result.

A guard bit predicates the writeback. A destination register tag rides along with the operation. The result, a write enable and the tag come out a fixed two cycles after the operands go in.

The operand side is a plain valid strobe, with no ready signal. The unit never applies back-pressure: it accepts a new operation on every cycle, whatever it accepted in earlier cycles. The consumer must take each result in the cycle it appears, because nothing is held. Register file, decode and issue logic sit outside the unit.

Top module: `sat_quad_adder`

## Requirements
- R1: Each operand word is split into four 8-bit lanes. Lane k occupies bits [8k+7:8k] in both sources and in the result, and no lane affects any other lane.
- R2: Each lane of `in_src_u` is treated as an unsigned value from 0 to 255. Each lane of `in_src_s` is treated as a two's-complement value from -128 to 127.
- R3: The lane sum is formed without loss, over the range -128 to 382. When the signed lane is non-negative, the result byte is never below the unsigned lane.
- R4: A negative lane sum gives 0x00, a sum above 255 gives 0xFF, and any other sum gives its value. When the signed lane is negative, the result byte is never above the unsigned lane.
- R5: `out_wen` is high only for an accepted operation whose `in_guard` was 1.
- R6: An operation accepted at a clock edge appears on `out_valid`, `out_data` and `out_tag` exactly two clock edges later. Its tag is unchanged.
- R7: An operation can be accepted on every cycle. Back-to-back operations and gaps in `in_valid` all come out in order, each with its own result and tag.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_wen` at the next edge. They stay low while `rst` is held, even if `in_valid` is high.
- R9: An accepted operation with `in_guard` at 0 still produces `out_valid` high, with `out_wen` low, so no destination write is issued.
- R10: Operands 0x02010001 and 0xFFFFFF01 give 0x01000002. Operands 0x9C9C6464 and 0x649C649C give 0xFF38C800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe; accepted on every cycle it is high |
| in_src_u | input | 32 | First operand: four unsigned byte lanes |
| in_src_s | input | 32 | Second operand: four signed byte lanes |
| in_guard | input | 1 | Predicate bit; 1 permits the destination write |
| in_tag | input | 5 | Destination register tag |
| out_valid | output | 1 | Result present this cycle |
| out_wen | output | 1 | Destination write enable (valid and guarded) |
| out_data | output | 32 | Four clamped unsigned result bytes |
| out_tag | output | 5 | Tag of the operation in `out_data` |

## Verification
The bench sweeps all 65536 byte pairs through every lane, and gives each lane a different pairing in every cycle. This exposes three kinds of fault:
- a unit that sign-extends the wrong operand,
- a unit that wraps instead of clamping at the 0x00 or 0xFF edge,
- a unit that leaks a carry between lanes.

These show up as wrong bytes near 0x80 and 0xFF, or as corrupted neighbouring lanes. Guard-false operations check that the result still arrives with the write enable low; an unpredicated enable would write the destination anyway. Bursts with gaps in the strobe, and tags that change every cycle, catch a unit whose latency is off by one cycle or whose tag slips relative to its data. Reset held with the strobe high catches an enable or valid bit that escapes the reset.

// File: rtl/sqa_pkg.sv
package sqa_pkg;
  typedef enum logic [1:0] {
    CLIP_PASS = 2'd0,
    CLIP_FLOOR = 2'd1,
    CLIP_CEIL = 2'd2
  } clip_kind_e;

  function automatic int unsigned sum_width(input int unsigned lane_w);
    return lane_w + 2;
  endfunction
endpackage

// File: rtl/sqa_lane_add.sv
module sqa_lane_add #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned SUM_W = sqa_pkg::sum_width(LANE_W)
) (
  input  logic [LANE_W-1:0] opnd_u,
  input  logic [LANE_W-1:0] opnd_s,
  output logic [SUM_W-1:0]  sum
);
  logic signed [SUM_W-1:0] ext_u;
  logic signed [SUM_W-1:0] ext_s;

  always_comb begin
    ext_u = $signed({2'b00, opnd_u});
    ext_s = $signed({{2{opnd_s[LANE_W-1]}}, opnd_s});
    sum   = ext_u + ext_s;
  end
endmodule

// File: rtl/sqa_lane_clip.sv
module sqa_lane_clip #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned SUM_W = sqa_pkg::sum_width(LANE_W)
) (
  input  logic [SUM_W-1:0]  sum,
  output logic [LANE_W-1:0] res
);
  import sqa_pkg::*;
  clip_kind_e kind;

  always_comb begin
    if (sum[SUM_W-1])
      kind = CLIP_FLOOR;
    else if (sum[SUM_W-2:LANE_W] != '0)
      kind = CLIP_CEIL;
    else
      kind = CLIP_PASS;
    unique case (kind)
      CLIP_FLOOR: res = '0;
      CLIP_CEIL:  res = '1;
      default:    res = sum[LANE_W-1:0];
    endcase
  end
endmodule

// File: rtl/sqa_ctrl_pipe.sv
module sqa_ctrl_pipe #(
  parameter int unsigned TAG_W = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic             grd_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic             wen_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [STAGES-1:0] vld_q;
  logic [STAGES-1:0] wen_q;
  logic [STAGES-1:0][TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      wen_q <= '0;
    end else begin
      vld_q[0] <= vld_i;
      wen_q[0] <= vld_i & grd_i;
      for (int s = 1; s < STAGES; s++) begin
        vld_q[s] <= vld_q[s-1];
        wen_q[s] <= wen_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    tag_q[0] <= tag_i;
    for (int s = 1; s < STAGES; s++) tag_q[s] <= tag_q[s-1];
  end

  assign vld_o = vld_q[STAGES-1];
  assign wen_o = wen_q[STAGES-1];
  assign tag_o = tag_q[STAGES-1];

  assert_wen_implies_vld_R5: assert property (@(posedge clk) disable iff (rst)
    wen_o |-> vld_o);
  assert_reset_clears_R8: assert property (@(posedge clk)
    $past(rst) |-> (!vld_o && !wen_o));
endmodule

// File: rtl/sat_quad_adder.sv
module sat_quad_adder #(
  parameter int unsigned LANES = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned TAG_W = 5,
  localparam int unsigned WORD_W = LANES * LANE_W,
  localparam int unsigned SUM_W = sqa_pkg::sum_width(LANE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_src_u,
  input  logic [WORD_W-1:0] in_src_s,
  input  logic              in_guard,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic              out_wen,
  output logic [WORD_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag
);
  logic [LANES-1:0][SUM_W-1:0]  add_sum;
  logic [LANES-1:0][SUM_W-1:0]  s1_sum;
  logic [LANES-1:0][LANE_W-1:0] clip_res;
  logic [WORD_W-1:0]            s2_data;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sqa_lane_add #(.LANE_W(LANE_W)) u_add (
      .opnd_u (in_src_u[g*LANE_W +: LANE_W]),
      .opnd_s (in_src_s[g*LANE_W +: LANE_W]),
      .sum    (add_sum[g])
    );
    sqa_lane_clip #(.LANE_W(LANE_W)) u_clip (
      .sum (s1_sum[g]),
      .res (clip_res[g])
    );

    assert_nonneg_no_drop_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !$past(in_src_s[g*LANE_W+LANE_W-1], 2))
        |-> (out_data[g*LANE_W +: LANE_W] >= $past(in_src_u[g*LANE_W +: LANE_W], 2)));
    assert_neg_no_rise_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(in_src_s[g*LANE_W+LANE_W-1], 2))
        |-> (out_data[g*LANE_W +: LANE_W] <= $past(in_src_u[g*LANE_W +: LANE_W], 2)));
  end

  always_ff @(posedge clk) begin
    s1_sum  <= add_sum;
    s2_data <= clip_res;
  end

  sqa_ctrl_pipe #(.TAG_W(TAG_W), .STAGES(2)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .vld_i (in_valid),
    .grd_i (in_guard),
    .tag_i (in_tag),
    .vld_o (out_valid),
    .wen_o (out_wen),
    .tag_o (out_tag)
  );

  assign out_data = s2_data;

  assert_latency_two_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  assert_wen_needs_guard_R5: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> $past(in_guard, 2));
  assert_unguarded_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(in_guard, 2)) |-> !out_wen);
endmodule

// File: tb/sat_quad_adder_bench.sv
module sat_quad_adder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_src_u = '0;
  logic [31:0] in_src_s = '0;
  logic in_guard = 1'b0;
  logic [4:0] in_tag = '0;
  logic out_valid, out_wen;
  logic [31:0] out_data;
  logic [4:0] out_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic h_v [2];
  logic h_w [2];
  logic [31:0] h_d [2];
  logic [4:0] h_t [2];
  string h_r [2];

  always #2.5 clk = ~clk;

  sat_quad_adder u_sat_quad_adder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src_u(in_src_u),
    .in_src_s(in_src_s), .in_guard(in_guard), .in_tag(in_tag),
    .out_valid(out_valid), .out_wen(out_wen), .out_data(out_data), .out_tag(out_tag)
  );

  function automatic logic [7:0] ref_lane(input logic [7:0] u, input logic [7:0] s);
    int t;
    t = int'(u) + int'($signed(s));
    if (t < 0) return 8'h00;
    if (t > 255) return 8'hFF;
    return t[7:0];
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] u, input logic [31:0] s);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = ref_lane(u[k*8 +: 8], s[k*8 +: 8]);
    return r;
  endfunction

  task automatic clear_hist();
    for (int i = 0; i < 2; i++) begin
      h_v[i] = 1'b0; h_w[i] = 1'b0; h_d[i] = '0; h_t[i] = '0; h_r[i] = "R8";
    end
  endtask

  // one cycle: check the result issued two steps ago, then drive a new one
  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic g, input logic [4:0] t, input string req);
    @(negedge clk);
    n_chk++;
    if (out_valid !== h_v[1] || out_wen !== h_w[1] ||
        (h_v[1] && (out_data !== h_d[1] || out_tag !== h_t[1]))) begin
      n_bad++;
      $display("FAIL %s: got v=%0b w=%0b d=%08h t=%0d, expected v=%0b w=%0b d=%08h t=%0d",
               h_r[1], out_valid, out_wen, out_data, out_tag,
               h_v[1], h_w[1], h_d[1], h_t[1]);
    end
    h_v[1] = h_v[0]; h_w[1] = h_w[0]; h_d[1] = h_d[0]; h_t[1] = h_t[0]; h_r[1] = h_r[0];
    h_v[0] = v; h_w[0] = v & g; h_d[0] = ref_word(a, b); h_t[0] = t; h_r[0] = req;
    in_valid = v; in_src_u = a; in_src_s = b; in_guard = g; in_tag = t;
  endtask

  task automatic flush();
    step(1'b0, '0, '0, 1'b0, '0, "R6");
    step(1'b0, '0, '0, 1'b0, '0, "R6");
  endtask

  // R8: reset holds valid and enable low even with the strobe high
  task automatic t_reset();
    rst = 1'b1;
    in_valid = 1'b1; in_guard = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_wen !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: got v=%0b w=%0b, expected v=0 w=0", out_valid, out_wen);
    end
    in_valid = 1'b0; in_guard = 1'b0;
    rst = 1'b0;
    clear_hist();
    flush();
  endtask

  // R10 and R9: worked operand pairs, guarded and unguarded
  task automatic t_examples();
    step(1'b1, 32'h02010001, 32'hFFFFFF01, 1'b1, 5'd5, "R10");
    step(1'b1, 32'h9C9C6464, 32'h649C649C, 1'b1, 5'd9, "R10");
    step(1'b1, 32'h9C9C6464, 32'h649C649C, 1'b0, 5'd8, "R9");
    flush();
    n_chk++;
    if (ref_word(32'h02010001, 32'hFFFFFF01) !== 32'h01000002 ||
        ref_word(32'h9C9C6464, 32'h649C649C) !== 32'hFF38C800) begin
      n_bad++;
      $display("FAIL R10: got model %08h, expected 01000002",
               ref_word(32'h02010001, 32'hFFFFFF01));
    end
  endtask

  // R1 R2 R3 R4 R7: all byte pairs through every lane, back to back, lanes skewed
  task automatic t_exhaustive();
    for (int idx = 0; idx < 65536; idx++) begin
      logic [31:0] a, b;
      for (int k = 0; k < 4; k++) begin
        a[k*8 +: 8] = 8'((idx >> 8) + 85 * k);
        b[k*8 +: 8] = 8'(idx + 51 * k);
      end
      step(1'b1, a, b, idx[0] | idx[3], 5'(idx), "R1_R2_R3_R4_R7");
    end
    flush();
  endtask

  // R5 R6: random words, guards and strobe gaps
  task automatic t_random();
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 3) != 0), $urandom, $urandom,
           1'($urandom), 5'($urandom), "R5_R6");
    end
    flush();
  endtask

  // R4: clamp edges in isolated lanes
  task automatic t_edges();
    step(1'b1, 32'hFF00FF80, 32'h7F807F80, 1'b1, 5'd1, "R4");
    step(1'b1, 32'h7F81FF00, 32'h80807F01, 1'b1, 5'd2, "R4");
    step(1'b1, 32'h00FF0180, 32'hFF01FF80, 1'b1, 5'd3, "R4");
    flush();
  endtask

  initial begin
    clear_hist();
    t_reset();
    t_examples();
    t_edges();
    t_exhaustive();
    t_random();
    t_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule